// File: doc/BRIEF.md
# Sub-Nanosecond Linear Time Counter

This block is a free-running, unsigned time base for packet timestamping. It stores time in units of 2^-40 ns in an 87-bit register. On every clock edge it adds a 42-bit increment that equals the clock period in the same units. Because the low bits sit below the resolution that is exposed, the increment can trim the counter rate by a tiny fraction of a nanosecond per cycle. Surrounding servo logic uses this to steer the time base.

A mode input chooses one of two built-in increments while reset is held. After reset a write strobe can replace the increment at any time. A separate load strobe sets the whole counter in one cycle, which serves as a coarse phase jump. Bits 63:32 of the counter form the timestamp slice, which counts in 2^-8 ns steps of about 3.9 ps. The full counter is also driven out as a reference from which wider timestamps can be rebuilt.

Top module: `ptp_fine_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter is cleared to zero. At the first edge after release, `time_now` and `ts_slice` read zero.
- R2: At each reset edge the increment register takes 42'h18D_3018_D302 when `alt_mode` is 0, or 42'h181_8181_8182 when `alt_mode` is 1. Outside reset, `alt_mode` has no effect.
- R3: At every edge where `rst_n` is high and `time_ld` is low, `time_now` becomes its previous value plus the current increment, zero-extended to 87 bits.
- R4: When `inc_we` is high at an edge, `inc_wdata` replaces the increment. The add at that same edge still uses the old increment, and the new value applies from the following edge on.
- R5: When `time_ld` is high at an edge, `time_now` becomes `time_ld_data` and no increment is added in that cycle. Counting resumes from the loaded value at the next edge.
- R6: `ts_slice` always equals bits 63:32 of `time_now`.
- R7: The sum wraps modulo 2^87 without any indication. Bits carried out of bit 86 are dropped.
- R8: If `time_ld` and `inc_we` are high at the same edge, the load wins for the counter. The newly written increment is then used from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_mode | input | 1 | Selects the alternate default increment; used only during reset |
| inc_we | input | 1 | Increment write strobe |
| inc_wdata | input | 42 | New increment in 2^-40 ns units |
| time_ld | input | 1 | Counter load strobe |
| time_ld_data | input | 87 | Value to load into the counter |
| ts_slice | output | 32 | Counter bits 63:32, 2^-8 ns per step |
| time_now | output | 87 | Full counter value |

## Verification
Both reset defaults are run freely for many cycles, and the increments seen in that run show which default was loaded. The bench then writes a sweep of increments: zero, one, the all-ones value, and a walking one across all 42 bit positions. The cycle right after each write shows whether the new value took effect one edge too early. A walking one across all 87 counter bit positions is loaded, with some loads sharing an edge with increment writes. This catches dropped load bits, wrong load priority and a miswired timestamp slice. Finally, values just below 2^87 combined with large increments exercise the silent wrap, and toggling the mode input outside reset confirms that it has no effect.

// File: rtl/ptp_fine_timer.sv
module ptp_fine_timer #(
  parameter int CNT_W = 87,
  parameter int INC_W = 42,
  parameter int TS_LO = 32,
  parameter int TS_W  = 32,
  parameter logic [INC_W-1:0] INC_DEF = 42'h18D_3018_D302,
  parameter logic [INC_W-1:0] INC_ALT = 42'h181_8181_8182
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_mode,
  input  logic             inc_we,
  input  logic [INC_W-1:0] inc_wdata,
  input  logic             time_ld,
  input  logic [CNT_W-1:0] time_ld_data,
  output logic [TS_W-1:0]  ts_slice,
  output logic [CNT_W-1:0] time_now
);

  logic [INC_W-1:0] inc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt  = time_ld ? time_ld_data : cnt_q + CNT_W'(inc_q);
  assign time_now = cnt_q;
  assign ts_slice = cnt_q[TS_LO +: TS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inc_q <= alt_mode ? INC_ALT : INC_DEF;
    end else begin
      cnt_q <= cnt_nxt;
      if (inc_we) inc_q <= inc_wdata;
    end
  end

endmodule

// File: rtl/ptp_fine_timer_chk.sv
module ptp_fine_timer_chk #(
  parameter int CNT_W = 87,
  parameter int INC_W = 42,
  parameter int TS_LO = 32,
  parameter int TS_W  = 32,
  parameter logic [INC_W-1:0] INC_DEF = 42'h18D_3018_D302,
  parameter logic [INC_W-1:0] INC_ALT = 42'h181_8181_8182
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alt_mode,
  input logic             inc_we,
  input logic [INC_W-1:0] inc_wdata,
  input logic             time_ld,
  input logic [CNT_W-1:0] time_ld_data,
  input logic [TS_W-1:0]  ts_slice,
  input logic [CNT_W-1:0] time_now
);

  logic [1:0]       rel_cnt = 2'd0;
  logic             seen_rst = 1'b0;
  logic             alt_seen = 1'b0;
  logic [INC_W-1:0] inc_mdl = '0;
  logic [CNT_W-1:0] time_mdl = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt  <= 2'd0;
      seen_rst <= 1'b1;
      alt_seen <= alt_mode;
      inc_mdl  <= alt_mode ? INC_ALT : INC_DEF;
      time_mdl <= '0;
    end else begin
      if (rel_cnt != 2'd3) rel_cnt <= rel_cnt + 2'd1;
      if (inc_we) inc_mdl <= inc_wdata;
      time_mdl <= time_ld ? time_ld_data : CNT_W'(time_mdl + CNT_W'(inc_mdl));
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && rel_cnt == 2'd0) |-> (time_now == '0 && ts_slice == '0));

  // R2
  default_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && rel_cnt == 2'd1 && !$past(time_ld)) |->
      time_now == CNT_W'(alt_seen ? INC_ALT : INC_DEF));

  // R3
  time_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_rst |-> time_now == time_mdl);

  // R4
  inc_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cnt >= 2'd2 && $past(inc_we, 2) && !$past(inc_we) && !$past(time_ld)) |->
      CNT_W'(time_now - $past(time_now)) == CNT_W'($past(inc_wdata, 2)));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cnt != 2'd0 && $past(time_ld)) |-> time_now == $past(time_ld_data));

  // R6
  slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_rst |-> ts_slice == time_mdl[TS_LO +: TS_W]);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cnt != 2'd0 && !$past(time_ld)) |->
      time_now == CNT_W'($past(time_now) + CNT_W'($past(inc_mdl))));

endmodule

bind ptp_fine_timer ptp_fine_timer_chk #(
  .CNT_W(CNT_W), .INC_W(INC_W), .TS_LO(TS_LO), .TS_W(TS_W),
  .INC_DEF(INC_DEF), .INC_ALT(INC_ALT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode), .inc_we(inc_we),
  .inc_wdata(inc_wdata), .time_ld(time_ld), .time_ld_data(time_ld_data),
  .ts_slice(ts_slice), .time_now(time_now)
);

// File: tb/tb_ptp_fine_timer.sv
`timescale 1ns/1ps
module tb_ptp_fine_timer;
  localparam int CW = 87;
  localparam int IW = 42;
  localparam logic [IW-1:0] DEF_A = 42'h18D_3018_D302;
  localparam logic [IW-1:0] DEF_B = 42'h181_8181_8182;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alt_mode = 1'b0;
  logic inc_we = 1'b0;
  logic [IW-1:0] inc_wdata = '0;
  logic time_ld = 1'b0;
  logic [CW-1:0] time_ld_data = '0;
  logic [31:0] ts_slice;
  logic [CW-1:0] time_now;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  logic [CW-1:0] exp_t;
  logic [IW-1:0] exp_i;

  always #2.5 clk = ~clk;

  ptp_fine_timer dut (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode), .inc_we(inc_we),
    .inc_wdata(inc_wdata), .time_ld(time_ld), .time_ld_data(time_ld_data),
    .ts_slice(ts_slice), .time_now(time_now)
  );

  task automatic check(input string tag);
    vecs++;
    if (time_now !== exp_t) begin
      errs++;
      $display("FAIL %s time_now=%h expected=%h", tag, time_now, exp_t);
    end
    vecs++;
    if (ts_slice !== exp_t[63:32]) begin
      errs++;
      $display("FAIL R6 (%s) ts_slice=%h expected=%h", tag, ts_slice, exp_t[63:32]);
    end
  endtask

  // drive at negedge, take one edge, update model, check at next negedge
  task automatic step(input bit ld, input logic [CW-1:0] ldd,
                      input bit wr, input logic [IW-1:0] wd, input string tag);
    time_ld = ld; time_ld_data = ldd; inc_we = wr; inc_wdata = wd;
    @(posedge clk);
    exp_t = ld ? ldd : CW'(exp_t + CW'(exp_i));
    if (wr) exp_i = wd;
    @(negedge clk);
    time_ld = 1'b0; inc_we = 1'b0;
    check(tag);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; alt_mode = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_t = '0;
    exp_i = m ? DEF_B : DEF_A;
    check("R1");
  endtask

  initial begin
    // R1 + R2 default, R3 free run
    do_reset(1'b0);
    for (int k = 0; k < 20; k++) step(1'b0, '0, 1'b0, '0, "R2/R3 default A");
    do_reset(1'b1);
    for (int k = 0; k < 20; k++) step(1'b0, '0, 1'b0, '0, "R2/R3 default B");
    // R2: alt_mode outside reset has no effect
    for (int k = 0; k < 8; k++) begin
      alt_mode = k[0];
      step(1'b0, '0, 1'b0, '0, "R2 alt ignored");
    end
    // R4: increment sweep
    step(1'b0, '0, 1'b1, '0, "R4 write zero");
    step(1'b0, '0, 1'b0, '0, "R4 zero inc");
    step(1'b0, '0, 1'b1, 42'd1, "R4 write one");
    step(1'b0, '0, 1'b0, '0, "R4 one inc");
    step(1'b0, '0, 1'b1, {IW{1'b1}}, "R4 write max");
    step(1'b0, '0, 1'b0, '0, "R4 max inc");
    for (int b = 0; b < IW; b++) begin
      step(1'b0, '0, 1'b1, IW'(1) << b, "R4 walk write");
      step(1'b0, '0, 1'b0, '0, "R4 walk run");
      step(1'b0, '0, 1'b0, '0, "R3 walk run");
    end
    // R5 + R8: load walking one
    for (int b = 0; b < CW; b++) begin
      if (b % 3 == 0)
        step(1'b1, CW'(1) << b, 1'b1, IW'(b * 977 + 5), "R8 load+write");
      else
        step(1'b1, CW'(1) << b, 1'b0, '0, "R5 load");
      step(1'b0, '0, 1'b0, '0, "R5 resume");
    end
    // R7: wrap
    step(1'b0, '0, 1'b1, {IW{1'b1}}, "R7 set inc");
    step(1'b1, {CW{1'b1}} - CW'(3), 1'b0, '0, "R7 load near top");
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, '0, "R7 wrap");
    step(1'b1, {CW{1'b1}}, 1'b1, 42'd1, "R7 load all ones");
    step(1'b0, '0, 1'b0, '0, "R7 wrap to zero");
    step(1'b0, '0, 1'b0, '0, "R7 after wrap");
    // R1 reset mid-run
    do_reset(1'b0);
    step(1'b0, '0, 1'b0, '0, "R2 after second reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule